// File: doc/BRIEF.md
# USB Endpoint Byte Buffer with Register Access

This block sits between a USB device packet engine and a bus register file. The engine delivers each received SETUP or OUT data packet as a byte stream: a start strobe that names the packet kind and endpoint, one strobe per byte, and an end strobe. The block keeps every byte of the packet, including the two trailing CRC16 bytes. Software takes the bytes out one at a time through a status, data and control register group. A status bit shows that bytes are waiting. The data register shows the head byte. A write to the control register moves to the next byte.

In the other direction, software pushes bytes for an IN transfer into an IN data register. It then writes an endpoint number, which arms the buffer for the engine. The engine reads the head byte, steps through the bytes with a pop strobe, and releases the buffer with a done strobe. Four enable masks gate which endpoints may receive or send. One more register drives the pull-up that attaches the device to the bus.

Top module: `usb_ep_bytebuf`

## Requirements
- R1: After reset, every register reads 0 and `pullup_en` and `in_go` are 0. Register addresses: 0 setup status, 1 setup data, 2 setup control, 3 out status, 4 out data, 5 out control, 6 in status, 7 in data, 8 in endpoint, 9 out-enable low, 10 out-enable high, 11 in-enable low, 12 in-enable high, 13 pull-up. An OUT start (`rx_setup`=0) sees `rx_nak`=1.
- R2: A SETUP packet (`rx_setup`=1) is stored byte for byte, the last two bytes included. While bytes remain, setup status (address 0) bit 0 reads 1 and setup data (address 1) shows the head byte. Writing a value with bit 0 set to setup control (address 2) advances to the next byte. Bit 0 clears after the last byte is taken.
- R3: An OUT packet is accepted only when all three of these hold: reception is enabled, the out buffer is empty, and the endpoint's out-enable bit is set. Otherwise `rx_nak` is 1 and the packet leaves no trace in out status (address 3). The `rx_nak` output follows `rx_setup` and `rx_ep` without delay.
- R4: Out status bits: bit 0 means bytes are pending, bit 1 is overflow, bit 2 means reception is enabled, and bits 7:4 hold the endpoint of the stored packet. Committing an OUT packet clears bit 2. Out control (address 5) bit 0 advances and bit 1 re-enables reception, so writing 3 does both. A new packet is accepted only after the buffer is drained.
- R5: A packet with more than 66 bytes (64 payload plus 2 CRC) is dropped. Its buffer's status bit 1 is set and bit 0 stays 0. Bit 1 stays set until software writes any value to that status register.
- R6: A SETUP packet that arrives while the setup buffer still holds bytes is discarded, and the held bytes are left unchanged.
- R7: Each write to in data (address 7) appends a byte while the IN buffer is not armed. Writes beyond 64 bytes are ignored. Reading address 7 returns the byte count.
- R8: Writing an endpoint number to address 8 arms the IN buffer. In status (address 6) then reads bit 0 = 1 and bits 7:4 = endpoint. `in_go` is 1 when that endpoint's in-enable bit is set. `in_byte` shows the head byte, and it reads 0 once every byte has been taken. `in_pop` advances the head. `in_done` disarms the buffer and empties it.
- R9: Arming with an empty IN buffer gives a zero-length packet: `in_go`=1 and `in_len`=0.
- R10: While the IN buffer is armed, writes to in data and to in endpoint have no effect.
- R11: The enable registers read back as written. Bit n of the low register gates endpoint n, and bit n of the high register gates endpoint 8+n. An armed endpoint whose in-enable bit is clear keeps `in_go` at 0.
- R12: Bit 0 of the pull-up register (address 13) drives `pullup_en` one cycle after the write.
- R13: Setup data and out data read 0 when their buffer holds no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both bus and engine sides |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| rx_start | input | 1 | Start of a received data packet |
| rx_setup | input | 1 | Packet kind at start: 1 SETUP, 0 OUT |
| rx_ep | input | 4 | Endpoint of the packet at start |
| rx_valid | input | 1 | One received byte on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End of the received packet, on a cycle of its own |
| rx_nak | output | 1 | An OUT packet for `rx_ep` would be refused |
| in_pop | input | 1 | Engine took the head IN byte |
| in_done | input | 1 | Engine finished the IN transfer |
| in_go | output | 1 | IN data armed for an enabled endpoint |
| in_ep | output | 4 | Armed IN endpoint |
| in_len | output | 7 | Bytes in the IN buffer |
| in_byte | output | 8 | Head IN byte |
| pullup_en | output | 1 | Pull-up attach control |

## Verification
A vector table sends OUT packets that differ in endpoint, length and enable state. Each vector separates one outcome from the others: acceptance into the low and high endpoint halves, refusal for a masked endpoint, a packet of exactly 66 bytes kept whole, and a 67-byte packet dropped as overflow. Directed sequences then check the points the table cannot reach. One shows the refusal that comes from a full buffer, as opposed to a disabled endpoint. Others show that a second SETUP leaves the first intact, that IN writes are frozen while the buffer is armed, how a zero-length arm behaves, and where the IN buffer saturates.

// File: rtl/usb_ep_bytebuf.sv
module usb_ep_bytebuf #(
  parameter int PAYLOAD   = 64,
  parameter int CRC_BYTES = 2,
  localparam int IW = $clog2(PAYLOAD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          rx_start,
  input  logic          rx_setup,
  input  logic [3:0]    rx_ep,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_eop,
  output logic          rx_nak,
  input  logic          in_pop,
  input  logic          in_done,
  output logic          in_go,
  output logic [3:0]    in_ep,
  output logic [IW-1:0] in_len,
  output logic [7:0]    in_byte,
  output logic          pullup_en
);
  localparam int RX_DEPTH = PAYLOAD + CRC_BYTES;
  localparam int CW  = $clog2(RX_DEPTH + 1);
  localparam int RAW = $clog2(RX_DEPTH);
  localparam int IAW = $clog2(PAYLOAD);
  localparam logic [3:0] A_SU_STAT = 4'd0, A_SU_DATA = 4'd1, A_SU_CTRL = 4'd2;
  localparam logic [3:0] A_OU_STAT = 4'd3, A_OU_DATA = 4'd4, A_OU_CTRL = 4'd5;
  localparam logic [3:0] A_IN_STAT = 4'd6, A_IN_DATA = 4'd7, A_IN_EP = 4'd8;
  localparam logic [3:0] A_EN_O0 = 4'd9, A_EN_O1 = 4'd10, A_EN_I0 = 4'd11;
  localparam logic [3:0] A_EN_I1 = 4'd12, A_PULL = 4'd13;

  logic [7:0]    rxm [2][RX_DEPTH];
  logic [CW-1:0] rlen [2];
  logic [CW-1:0] rptr [2];
  logic [7:0]    rd_byte [2];
  logic [1:0]    ovf, pop, clr_ovf, pend;
  logic [CW-1:0] fill;
  logic          tgt_on, tgt, pkt_ovf, out_rx_en;
  logic [3:0]    tgt_ep, out_ep_q;
  logic [7:0]    en_o0, en_o1, en_i0, en_i1;
  logic          pull;
  logic [7:0]    inm [PAYLOAD];
  logic [IW-1:0] icnt, irdp;
  logic          iarm;
  logic [3:0]    iep;

  wire wr_su_ctrl = reg_we && reg_addr == A_SU_CTRL;
  wire wr_ou_ctrl = reg_we && reg_addr == A_OU_CTRL;
  wire wr_in_data = reg_we && reg_addr == A_IN_DATA && !iarm && icnt != IW'(PAYLOAD);
  wire wr_in_ep   = reg_we && reg_addr == A_IN_EP && !iarm;
  wire rx_byte    = tgt_on && rx_valid && !rx_start;
  wire out_en_bit = rx_ep[3] ? en_o1[rx_ep[2:0]] : en_o0[rx_ep[2:0]];
  wire in_en_bit  = iep[3] ? en_i1[iep[2:0]] : en_i0[iep[2:0]];
  wire out_ok     = out_rx_en && rlen[1] == '0 && out_en_bit;
  wire setup_ok   = rlen[0] == '0;

  assign pop     = {wr_ou_ctrl && reg_wdata[0], wr_su_ctrl && reg_wdata[0]};
  assign clr_ovf = {reg_we && reg_addr == A_OU_STAT, reg_we && reg_addr == A_SU_STAT};
  assign rx_nak  = !rx_setup && !out_ok;

  always_comb
    for (int g = 0; g < 2; g++) begin
      pend[g]    = rlen[g] != '0;
      rd_byte[g] = pend[g] ? rxm[g][rptr[g][RAW-1:0]] : 8'h00;
    end

  always_ff @(posedge clk)
    if (rx_byte && fill != CW'(RX_DEPTH)) rxm[tgt][fill[RAW-1:0]] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_on <= 1'b0; tgt <= 1'b0; tgt_ep <= '0; fill <= '0; pkt_ovf <= 1'b0;
      out_rx_en <= 1'b0; out_ep_q <= '0; ovf <= '0;
      for (int g = 0; g < 2; g++) begin rlen[g] <= '0; rptr[g] <= '0; end
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (pop[g] && pend[g]) begin
          if (rptr[g] + 1'b1 == rlen[g]) begin rptr[g] <= '0; rlen[g] <= '0; end
          else rptr[g] <= rptr[g] + 1'b1;
        end
        if (clr_ovf[g]) ovf[g] <= 1'b0;
      end
      if (wr_ou_ctrl && reg_wdata[1]) out_rx_en <= 1'b1;
      if (rx_start) begin
        tgt_on <= rx_setup ? setup_ok : out_ok;
        tgt <= !rx_setup; tgt_ep <= rx_ep; fill <= '0; pkt_ovf <= 1'b0;
      end else if (rx_byte) begin
        if (fill == CW'(RX_DEPTH)) pkt_ovf <= 1'b1;
        else fill <= fill + 1'b1;
      end else if (tgt_on && rx_eop) begin
        tgt_on <= 1'b0;
        if (pkt_ovf) ovf[tgt] <= 1'b1;
        else begin
          rlen[tgt] <= fill; rptr[tgt] <= '0;
          if (tgt) begin out_rx_en <= 1'b0; out_ep_q <= tgt_ep; end
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (wr_in_data) inm[icnt[IAW-1:0]] <= reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iarm <= 1'b0; icnt <= '0; irdp <= '0; iep <= '0;
    end else if (in_done && iarm) begin
      iarm <= 1'b0; icnt <= '0; irdp <= '0;
    end else begin
      if (wr_in_data) icnt <= icnt + 1'b1;
      if (wr_in_ep) begin iarm <= 1'b1; iep <= reg_wdata[3:0]; end
      if (in_pop && iarm && irdp != icnt) irdp <= irdp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o0 <= '0; en_o1 <= '0; en_i0 <= '0; en_i1 <= '0; pull <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_EN_O0: en_o0 <= reg_wdata;
        A_EN_O1: en_o1 <= reg_wdata;
        A_EN_I0: en_i0 <= reg_wdata;
        A_EN_I1: en_i1 <= reg_wdata;
        A_PULL:  pull  <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign in_go     = iarm && in_en_bit;
  assign in_ep     = iep;
  assign in_len    = icnt;
  assign in_byte   = (irdp < icnt) ? inm[irdp[IAW-1:0]] : 8'h00;
  assign pullup_en = pull;

  always_comb begin
    case (reg_addr)
      A_SU_STAT: reg_rdata = {6'b0, ovf[0], pend[0]};
      A_SU_DATA: reg_rdata = rd_byte[0];
      A_OU_STAT: reg_rdata = {out_ep_q, 1'b0, out_rx_en, ovf[1], pend[1]};
      A_OU_DATA: reg_rdata = rd_byte[1];
      A_IN_STAT: reg_rdata = {iep, 3'b0, iarm};
      A_IN_DATA: reg_rdata = 8'(icnt);
      A_EN_O0:   reg_rdata = en_o0;
      A_EN_O1:   reg_rdata = en_o1;
      A_EN_I0:   reg_rdata = en_i0;
      A_EN_I1:   reg_rdata = en_i1;
      A_PULL:    reg_rdata = {7'b0, pull};
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/usb_ep_bytebuf_chk.sv
module usb_ep_bytebuf_chk #(
  parameter int PAYLOAD = 64,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    reg_addr,
  input logic          reg_we,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          rx_setup,
  input logic          rx_nak,
  input logic          in_done,
  input logic          in_go,
  input logic [IW-1:0] in_len,
  input logic          pullup_en
);
  // R8
  in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> (in_len == '0 && !in_go));
  // R10
  armed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_go && !in_done) |=> (in_len == $past(in_len)));
  // R12
  pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd13) |=> (pullup_en == $past(reg_wdata[0])));
  // R3
  busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_setup && reg_addr == 4'd3 && reg_rdata[0]) |-> rx_nak);
  // R7
  in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_len <= IW'(PAYLOAD));
endmodule

bind usb_ep_bytebuf usb_ep_bytebuf_chk #(.PAYLOAD(PAYLOAD), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_setup(rx_setup),
  .rx_nak(rx_nak), .in_done(in_done), .in_go(in_go), .in_len(in_len),
  .pullup_en(pullup_en)
);

// File: tb/usb_ep_bytebuf_tb.sv
module usb_ep_bytebuf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0; logic reg_we = 1'b0; logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rx_start = 0, rx_setup = 0, rx_valid = 0, rx_eop = 0;
  logic [3:0] rx_ep = '0; logic [7:0] rx_data = '0;
  logic rx_nak, in_pop = 0, in_done = 0, in_go, pullup_en;
  logic [3:0] in_ep; logic [6:0] in_len; logic [7:0] in_byte;
  int tests = 0, fails = 0; bit done = 0;

  usb_ep_bytebuf u_dut (.*);

  always #5 clk = ~clk;

  // {ep, mode(0 nak,1 accept,2 overflow), length}
  localparam logic [15:0] VEC [7] = '{
    {4'd0, 4'd1, 8'd3}, {4'd2, 4'd1, 8'd66}, {4'd5, 4'd0, 8'd4},
    {4'd15, 4'd1, 8'd1}, {4'd9, 4'd0, 8'd2}, {4'd1, 4'd2, 8'd67},
    {4'd3, 4'd1, 8'd10}};

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return 8'(base + i * 7);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send(input bit su, input logic [3:0] ep, input int n, input logic [7:0] base);
    @(negedge clk); rx_start = 1; rx_setup = su; rx_ep = ep;
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < n; i++) begin rx_valid = 1; rx_data = pat(base, i); @(negedge clk); end
    rx_valid = 0; rx_eop = 1; @(negedge clk); rx_eop = 0;
  endtask

  task automatic nak_is(input string req, input logic [3:0] ep, input int exp);
    @(negedge clk); rx_setup = 0; rx_ep = ep; #1 chk(req, rx_nak, exp);
  endtask

  task automatic pulse_pop; @(negedge clk); in_pop = 1; @(negedge clk); in_pop = 0; endtask
  task automatic pulse_done; @(negedge clk); in_done = 1; @(negedge clk); in_done = 0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 14; a++) begin rd(4'(a), v); chk("R1 reg", v, 0); end
    chk("R1 pullup", pullup_en, 0); chk("R1 in_go", in_go, 0);
    nak_is("R1 nak", 4'd0, 1);
    // R11 enables read back
    wr(4'd9, 8'h0F); wr(4'd10, 8'h80); wr(4'd11, 8'h04); wr(4'd12, 8'h5A);
    rd(4'd9, v); chk("R11 en_o0", v, 8'h0F); rd(4'd10, v); chk("R11 en_o1", v, 8'h80);
    rd(4'd11, v); chk("R11 en_i0", v, 8'h04); rd(4'd12, v); chk("R11 en_i1", v, 8'h5A);
    // R12 pull-up
    wr(4'd13, 8'h01); chk("R12 on", pullup_en, 1);
    wr(4'd13, 8'hFE); chk("R12 off", pullup_en, 0);
    // R3 reception not enabled yet
    nak_is("R3 disabled", 4'd0, 1);
    send(0, 4'd0, 3, 8'h20); rd(4'd3, v); chk("R3 dropped", v, 0);
    // table of OUT packets
    foreach (VEC[k]) begin
      logic [3:0] ep; int mode, n;
      ep = VEC[k][15:12]; mode = int'(VEC[k][11:8]); n = int'(VEC[k][7:0]);
      wr(4'd5, 8'h02);
      nak_is("R3 table nak", ep, mode == 0);
      send(0, ep, n, 8'(ep * 16 + 3));
      rd(4'd3, v);
      chk("R4/R5 table stat", v[2:0], mode == 1 ? 1 : (mode == 0 ? 4 : 6));
      if (mode == 1) begin
        chk("R4 table ep", v[7:4], ep);
        for (int i = 0; i < n; i++) begin
          rd(4'd4, v); chk("R2/R4 table byte", v, pat(8'(ep * 16 + 3), i));
          wr(4'd5, 8'h03);
        end
        rd(4'd3, v); chk("R4 table drained", v[0], 0);
      end
      if (mode == 2) begin
        wr(4'd3, 8'h00); rd(4'd3, v); chk("R5 ovf clear", v[1], 0);
      end
    end
    // R4 full buffer refuses until drained
    wr(4'd5, 8'h02); send(0, 4'd0, 2, 8'h60);
    rd(4'd3, v); chk("R4 enable cleared", v[2], 0);
    nak_is("R4 full nak", 4'd0, 1);
    wr(4'd5, 8'h03); nak_is("R4 nonempty nak", 4'd0, 1);
    wr(4'd5, 8'h03); nak_is("R4 drained accept", 4'd0, 0);
    // R2 setup packet with trailing CRC bytes
    send(1, 4'd0, 10, 8'h40);
    rd(4'd0, v); chk("R2 pending", v, 1);
    for (int i = 0; i < 10; i++) begin
      rd(4'd1, v); chk("R2 byte", v, pat(8'h40, i)); wr(4'd2, 8'h01);
    end
    rd(4'd0, v); chk("R2 empty", v, 0);
    rd(4'd1, v); chk("R13 empty data", v, 0);
    // R6 second setup discarded
    send(1, 4'd0, 3, 8'h10); send(1, 4'd0, 3, 8'h90);
    for (int i = 0; i < 3; i++) begin
      rd(4'd1, v); chk("R6 kept", v, pat(8'h10, i)); wr(4'd2, 8'h01);
    end
    rd(4'd0, v); chk("R6 drained", v, 0);
    // IN path
    wr(4'd7, 8'hA1); wr(4'd7, 8'hA2); wr(4'd7, 8'hA3);
    rd(4'd7, v); chk("R7 count", v, 3);
    rd(4'd6, v); chk("R8 idle stat", v, 0);
    wr(4'd8, 8'h02);
    rd(4'd6, v); chk("R8 armed stat", v, 8'h21);
    chk("R8 go", in_go, 1); chk("R8 len", in_len, 3); chk("R8 head", in_byte, 8'hA1);
    chk("R8 ep", in_ep, 2);
    wr(4'd7, 8'h55); wr(4'd8, 8'h05);
    chk("R10 len", in_len, 3); rd(4'd6, v); chk("R10 stat", v, 8'h21);
    pulse_pop; #1 chk("R8 pop1", in_byte, 8'hA2);
    pulse_pop; pulse_pop; #1 chk("R8 consumed", in_byte, 0);
    pulse_done; chk("R8 done go", in_go, 0); chk("R8 done len", in_len, 0);
    rd(4'd6, v); chk("R8 done stat", v[0], 0);
    wr(4'd8, 8'h02); chk("R9 zlp go", in_go, 1); chk("R9 zlp len", in_len, 0);
    pulse_done;
    wr(4'd8, 8'h05); rd(4'd6, v); chk("R11 armed", v[0], 1); chk("R11 masked go", in_go, 0);
    pulse_done;
    for (int i = 0; i < 66; i++) wr(4'd7, 8'(i));
    rd(4'd7, v); chk("R7 saturate", v, 64);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule